// File: doc/BRIEF.md
# Sticky Link-Health Monitor with Duty-Cycle Meters

This block watches the nine health flags of one serial link while a test-enable input is high. It gives three views of those flags. The first is the live flags. The second is a latched "never failed" copy that starts at all ones and loses a bit when that flag is seen low during a test cycle. The third is a set of ten 16-bit duty-cycle readings: one for each flag, and one for the test-enable input itself. Full scale on every reading is 0x8000, which stands for 100%.

Flag order, from bit 8 down to bit 0:
- bit 8: heartbeat good
- bit 7: data valid
- bit 6: ready
- bit 5: is-data
- bit 4: header locked
- bit 3: receive PLL locked
- bit 2: clock-recovery locked
- bit 1: system reference clock
- bit 0: system master

All pins are plain level signals. The flags are sampled on every clock with no handshake, and the outputs hold their values until the block updates them. There is no data stream, so there is no back-pressure.

Each reading covers a window of 2^`WIN_LOG2` samples, and the count of ones in that window is scaled up to the 0x8000 range. The flag meters only count cycles in which the test input is high. The test-input meter counts every clock cycle.

Top module: `lnkmon_top`

## Requirements
- R1: `status_word[8:0]` equals `status_in[8:0]` in the same cycle, with no register in the path. The bit order is the flag order listed above.
- R2: `status_word[15:9]` and `status_word[31:25]` always read zero.
- R3: After reset, and on the clock edge after any cycle with `sticky_clr` high, `status_word[24:16]` is all ones. `sticky_clr` takes priority over a failure seen in the same cycle.
- R4: If `test_en` is 1, `sticky_clr` is 0 and `status_in[i]` is 0 in a cycle, then `status_word[16+i]` is 0 after that clock edge.
- R5: A sticky bit never returns to 1 except through R3. A low flag seen while `test_en` is 0 has no effect on the sticky bits.
- R6: Every reading equals the count of ones in its window shifted left by 15-`WIN_LOG2`. A window of all ones therefore reads exactly 0x8000, and no reading ever exceeds 0x8000.
- R7: `rate_flat[16*i+15:16*i]` is the reading for flag i. Its window closes after 2^`WIN_LOG2` cycles with `test_en` high, and it counts the cycles among those where flag i was 1. The value appears at the clock edge that takes the last sample of the window.
- R8: `en_rate` counts the cycles with `test_en` high in consecutive windows of 2^`WIN_LOG2` clock cycles. The first window starts at the first edge after reset is released. The value appears at the edge that takes the last sample of the window.
- R9: All readings are zero after reset until their first window closes. Between window closes, each reading holds its value.
- R10: The flag-meter window does not advance on cycles with `test_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sticky_clr | input | 1 | Sets all sticky bits to one |
| test_en | input | 1 | Test active; gates sticky clearing and flag sampling |
| status_in | input | 9 | Live link-health flags |
| status_word | output | 32 | {7'b0, sticky[8:0], 7'b0, live[8:0]} |
| rate_flat | output | 144 | Nine 16-bit flag duty readings, flag i at bits 16*i+15:16*i |
| en_rate | output | 16 | Duty reading of test_en |

## Verification
The hardest case to produce from the ports is a flag-meter window that is interrupted by idle cycles. In that case the flag window and the free-running test-input window close on different edges. The bench reaches it by dropping `test_en` at random for long stretches, including one run of 40 idle cycles. It also builds the design with a 16-sample window so that many windows close during a short run. A reference model pushes the expected value of every window close into a queue with its edge number, and a monitor pops each entry on that edge.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;
  localparam int ST_W      = 9;
  localparam int RATE_W    = 16;
  localparam int FULL_LOG2 = 15;
  localparam logic [RATE_W-1:0] FULL_SCALE = 16'h8000;
endpackage

// File: rtl/lnkmon_win_timer.sv
module lnkmon_win_timer #(
  parameter int WIN_LOG2 = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic last
);
  logic [WIN_LOG2-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  assign last = adv && (&cnt_q);

  // R10: window position frozen while not advancing
  p_win_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q));
endmodule

// File: rtl/lnkmon_duty_meter.sv
module lnkmon_duty_meter
  import lnkmon_pkg::*;
#(
  parameter int WIN_LOG2 = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              last,
  input  logic              bit_in,
  output logic [RATE_W-1:0] rate
);
  localparam int SH = FULL_LOG2 - WIN_LOG2;

  logic [WIN_LOG2:0] acc_q;
  logic [WIN_LOG2:0] sum;
  logic [RATE_W-1:0] rate_q;

  assign sum = acc_q + {{WIN_LOG2{1'b0}}, bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rate_q <= '0;
    end else if (adv) begin
      if (last) begin
        rate_q <= RATE_W'(sum) << SH;
        acc_q  <= '0;
      end else begin
        acc_q  <= sum;
      end
    end
  end

  assign rate = rate_q;

  initial begin
    p_win_range_r6: assert (WIN_LOG2 >= 1 && WIN_LOG2 <= FULL_LOG2);
  end

  p_rate_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rate <= FULL_SCALE);
  p_rate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && last) |=> $stable(rate));
endmodule

// File: rtl/lnkmon_sticky.sv
module lnkmon_sticky
  import lnkmon_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            test_en,
  input  logic [ST_W-1:0] status_in,
  output logic [ST_W-1:0] sticky
);
  logic [ST_W-1:0] sticky_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) sticky_q <= '1;
    else if (test_en)  sticky_q <= sticky_q & status_in;
  end

  assign sticky = sticky_q;

  p_clr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (&sticky));
  p_fail_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && test_en) |=> ((sticky & ~$past(status_in)) == '0));
  p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((sticky & ~$past(sticky)) == '0));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !test_en) |=> $stable(sticky));
endmodule

// File: rtl/lnkmon_top.sv
module lnkmon_top
  import lnkmon_pkg::*;
#(
  parameter int WIN_LOG2 = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sticky_clr,
  input  logic                   test_en,
  input  logic [ST_W-1:0]        status_in,
  output logic [31:0]            status_word,
  output logic [ST_W*RATE_W-1:0] rate_flat,
  output logic [RATE_W-1:0]      en_rate
);
  localparam int PAD_W = 16 - ST_W;

  logic [ST_W-1:0] sticky;
  logic            st_last;
  logic            en_last;

  lnkmon_sticky u_sticky (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (sticky_clr),
    .test_en   (test_en),
    .status_in (status_in),
    .sticky    (sticky)
  );

  lnkmon_win_timer #(.WIN_LOG2(WIN_LOG2)) u_st_win (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (test_en),
    .last  (st_last)
  );

  lnkmon_win_timer #(.WIN_LOG2(WIN_LOG2)) u_en_win (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (1'b1),
    .last  (en_last)
  );

  for (genvar i = 0; i < ST_W; i++) begin : g_flag
    lnkmon_duty_meter #(.WIN_LOG2(WIN_LOG2)) u_meter (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (test_en),
      .last   (st_last),
      .bit_in (status_in[i]),
      .rate   (rate_flat[RATE_W*i +: RATE_W])
    );
  end

  lnkmon_duty_meter #(.WIN_LOG2(WIN_LOG2)) u_en_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (1'b1),
    .last   (en_last),
    .bit_in (test_en),
    .rate   (en_rate)
  );

  assign status_word = {{PAD_W{1'b0}}, sticky, {PAD_W{1'b0}}, status_in};

  // R1: live field follows the input within the cycle
  p_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[ST_W-1:0] == status_in);
endmodule

// File: tb/lnkmon_top_tb.sv
`timescale 1ns/1ps
module lnkmon_top_tb;
  localparam int W  = 4;
  localparam int N  = 1 << W;
  localparam int SH = 15 - W;

  typedef struct {
    int          edge_no;
    int          idx;
    logic [15:0] val;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sticky_clr = 1'b0;
  logic         test_en = 1'b0;
  logic [8:0]   status_in = '0;
  logic [31:0]  status_word;
  logic [143:0] rate_flat;
  logic [15:0]  en_rate;

  int   n_tests = 0;
  int   n_fail = 0;
  int   edge_n = 0;
  bit   done = 0;
  exp_t sb_q[$];

  logic [8:0]  sticky_m;
  int          sacc[9];
  int          scnt, tacc, tcnt;
  logic [15:0] exp_r[10];

  always #2.5 clk = ~clk;

  lnkmon_top #(.WIN_LOG2(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sticky_clr(sticky_clr), .test_en(test_en),
    .status_in(status_in), .status_word(status_word),
    .rate_flat(rate_flat), .en_rate(en_rate)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input int i);
    return (i == 9) ? en_rate : rate_flat[16*i +: 16];
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " R1 R2 R3 R4 R5 status_word"}, status_word,
        {7'b0, sticky_m, 7'b0, status_in});
    for (int i = 0; i < 10; i++)
      chk({tag, " R9 rate hold"}, {16'b0, rd(i)}, {16'b0, exp_r[i]});
  endtask

  task automatic model_reset();
    sticky_m = '1;
    scnt = 0; tcnt = 0; tacc = 0;
    for (int i = 0; i < 9; i++) sacc[i] = 0;
    for (int i = 0; i < 10; i++) exp_r[i] = '0;
  endtask

  task automatic step(input logic [8:0] st, input logic ten, input logic clr);
    exp_t e;
    status_in = st; test_en = ten; sticky_clr = clr;
    @(posedge clk); #1;
    edge_n++;
    if (clr) sticky_m = '1;
    else if (ten) sticky_m = sticky_m & st;
    tacc += int'(ten); tcnt++;
    if (tcnt == N) begin
      exp_r[9] = 16'(tacc << SH);
      e.edge_no = edge_n; e.idx = 9; e.val = exp_r[9]; sb_q.push_back(e);
      tcnt = 0; tacc = 0;
    end
    if (ten) begin
      for (int i = 0; i < 9; i++) sacc[i] += int'(st[i]);
      scnt++;
      if (scnt == N) begin
        for (int i = 0; i < 9; i++) begin
          exp_r[i] = 16'(sacc[i] << SH);
          e.edge_no = edge_n; e.idx = i; e.val = exp_r[i]; sb_q.push_back(e);
          sacc[i] = 0;
        end
        scnt = 0;
      end
    end
    check_all("step");
  endtask

  // Monitor: pops expected window results on their edge
  initial begin
    forever begin
      @(posedge clk); #2;
      while (sb_q.size() > 0 && sb_q[0].edge_no <= edge_n) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.idx == 9) chk("R8 R6 window close en_rate", {16'b0, rd(9)}, {16'b0, e.val});
        else            chk("R7 R6 window close flag rate", {16'b0, rd(e.idx)}, {16'b0, e.val});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R3 R9: reset state
    chk("R3 reset sticky", {23'b0, status_word[24:16]}, 32'h1FF);
    for (int i = 0; i < 10; i++) chk("R9 reset rate", {16'b0, rd(i)}, 32'h0);
    rst_n = 1'b1;

    // R1 R5: live field, idle failures ignored
    step(9'h0AA, 1'b0, 1'b0);
    step(9'h155, 1'b0, 1'b0);
    step(9'h000, 1'b0, 1'b0);
    step(9'h1FF, 1'b0, 1'b0);
    chk("R5 idle failure ignored", {23'b0, status_word[24:16]}, 32'h1FF);

    // R4: receive PLL lock (bit 3) low under test drops its sticky bit
    step(9'h1F7, 1'b1, 1'b0);
    chk("R4 sticky bit3 dropped", {23'b0, status_word[24:16]}, 32'h1F7);
    step(9'h1FF, 1'b1, 1'b0);
    chk("R5 stays low", {23'b0, status_word[24:16]}, 32'h1F7);
    step(9'h0FF, 1'b0, 1'b0);

    // R3: clear wins over simultaneous failure
    step(9'h1FE, 1'b1, 1'b1);
    chk("R3 clear priority", {23'b0, status_word[24:16]}, 32'h1FF);

    // R6: full window of ones
    for (int k = 0; k < 2 * N; k++) step(9'h1FF, 1'b1, 1'b0);
    chk("R6 full scale", {16'b0, rate_flat[15:0]}, 32'h8000);
    chk("R2 pad zero", {status_word[31:25], status_word[15:9]}, 32'h0);

    // Random mix with gaps in test_en
    for (int k = 0; k < 400; k++) begin
      logic [8:0] st;
      for (int b = 0; b < 9; b++) st[b] = (($urandom % 16) < (b + 6));
      step(st, (($urandom % 10) < 6), (($urandom % 50) == 0));
    end

    // R10: long idle stretch; flag readings must hold
    for (int k = 0; k < 40; k++) step(9'h000, 1'b0, 1'b0);
    chk("R8 idle window", {16'b0, en_rate}, 32'h0);
    for (int k = 0; k < 3 * N; k++) step(9'h0F0, 1'b1, 1'b0);

    @(posedge clk); #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule